// File: doc/BRIEF.md
# Burst Write Acknowledge Controller

This block is the slave side of a 32-bit synchronous bus for write transfers. A master presents a 28-bit address, a direction line and a 2-bit size code, then pulses an active-low start strobe for one clock. If the transfer is a write and its upper address bits match a configured window, the controller takes ownership of it. It then paces each data beat with a programmable wait-state countdown and returns an active-low acknowledge for each beat.

A single transfer (byte, word or longword) completes in one beat. A line transfer completes in four longword beats, and the beat address wraps inside the 16-byte line. For each acknowledged beat, the controller latches the write data. Byte lanes outside the transfer are cleared to zero, and the latched data is presented with its beat address and lane enables. The acknowledge line has three states, given by a drive-enable and a level. After the last beat it is driven high for one clock and then released.

Top module: `burst_wr_ack_ctrl`

## Requirements
- R1: A start strobe (`ts_n` low) seen while idle is claimed only if `rw` is 0 and `(addr[27:20] ^ cfg_base) & cfg_mask` is zero. An unclaimed strobe leaves `ack_oe` and `wr_valid` at 0.
- R2: For a claimed transfer with wait count W (`cfg_wait`, held stable), each beat lasts W+1 cycles. The first beat starts in the cycle after the strobe is sampled. In a beat, `ack_oe` is 1 and `ack_n` is 1 for W cycles, then `ack_n` is 0 for exactly one cycle.
- R3: With W = 0, acknowledge is asserted in the first cycle of every beat, so a line gives four consecutive acknowledge cycles.
- R4: Size code 11 (line) runs four beats. Beat k reports address bits [3:2] as (captured [3:2] + k) mod 4, and all other bits are unchanged. Codes 00 (longword), 01 (byte) and 10 (word) run one beat at the captured address.
- R5: Lane enables are big-endian, with `wr_be[3]` carrying `data[31:24]` at offset 0. Longword and line give 1111. A word gives 1100 when addr[1] is 0 and 0011 when it is 1. A byte gives 1000 shifted right by addr[1:0]. Disabled lanes of `wr_data` read zero.
- R6: After the last acknowledge cycle, `ack_oe` is 1 with `ack_n` at 1 for one cycle, and then `ack_oe` goes to 0.
- R7: `wr_valid` pulses in the cycle after each acknowledge cycle. In that pulse, `wr_data` holds the bus data driven during the acknowledge cycle, and `wr_addr` holds that beat's address.
- R8: A start strobe that arrives while a transfer is in progress is ignored. The current transfer's timing, addresses and data are unchanged.
- R9: Under reset, `ack_oe` and `wr_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wait | input | 4 | Wait states per beat |
| cfg_base | input | 8 | Window base for addr[27:20] |
| cfg_mask | input | 8 | Compare mask for addr[27:20] |
| ts_n | input | 1 | Transfer start strobe, active low |
| rw | input | 1 | Direction, 0 = write |
| siz | input | 2 | Size code |
| addr | input | 28 | Transfer address |
| data | input | 32 | Write data byte lanes |
| ack_oe | output | 1 | Acknowledge drive enable (0 = released) |
| ack_n | output | 1 | Acknowledge level when driven, active low |
| wr_valid | output | 1 | Latched beat valid |
| wr_addr | output | 28 | Latched beat address |
| wr_data | output | 32 | Latched data, disabled lanes zero |
| wr_be | output | 4 | Latched lane enables |

## Verification
For a strobe sampled at edge 0, the acknowledge pair is due in cycle 1 + k(W+1) + W for beat k. The release cycle is due at 1 + n(W+1), where n is the number of beats. The latched beat appears one cycle after its acknowledge. The bench numbers the cycles after the strobe and computes the expected acknowledge level, enable and beat record for every cycle from these formulas. It samples on the falling edge, and it drives fresh bus data every cycle so that a beat latched one cycle early or late is detected. Unclaimed and mid-transfer strobes are checked over the same window, against an expected quiet or unchanged response.

// File: rtl/bwa_pkg.sv
// Shared types and helpers for the burst write acknowledge controller.
// Assumes a 32-bit big-endian port: lane 3 carries the lowest byte offset.
package bwa_pkg;

    typedef enum logic [1:0] {
        SZ_LONG = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_WORD = 2'b10,
        SZ_LINE = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_BEAT = 2'b01,
        ST_TAIL = 2'b10
    } state_e;

    // Lane enables for one beat from size code and low address bits.
    function automatic logic [3:0] lane_sel(input logic [1:0] sz, input logic [1:0] lo);
        logic [3:0] be;
        case (sz)
            SZ_BYTE: be = 4'b1000 >> lo;
            SZ_WORD: be = lo[1] ? 4'b0011 : 4'b1100;
            default: be = 4'b1111;
        endcase
        return be;
    endfunction

    // Expand lane enables to a bit mask over the data bus.
    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/bwa_claim.sv
// Decides whether a start strobe belongs to this slave.
// Assumes the strobe is active low and only writes are served.
module bwa_claim #(
    parameter int ADDR_W = 28,
    parameter int SEL_W  = 8
) (
    input  logic              ts_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEL_W-1:0]  cfg_base,
    input  logic [SEL_W-1:0]  cfg_mask,
    output logic              hit
);
    localparam int SEL_LO = ADDR_W - SEL_W;

    // Window compare on the upper address bits under the mask.
    always_comb begin
        hit = !ts_n && !rw &&
              (((addr[ADDR_W-1:SEL_LO] ^ cfg_base) & cfg_mask) == '0);
    end
endmodule

// File: rtl/bwa_wait_timer.sv
// Per-beat wait-state down counter; flags when the current beat may acknowledge.
// Assumes load and countdown are never requested in the same cycle by intent;
// load wins.
module bwa_wait_timer #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              expired
);
    logic [WAIT_W-1:0] cnt_q;

    // Reload at beat start, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/burst_wr_ack_ctrl.sv
// Slave acknowledge controller for single and four-beat line write bursts.
// Captures the transfer on the start strobe, paces every beat with a wait
// countdown, latches lane-masked data per acknowledge, then drives the
// acknowledge high for one cycle and releases it.
// Assumes a 32-bit port and a cfg_wait that is stable during a transfer.
module burst_wr_ack_ctrl #(
    parameter int ADDR_W = 28,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 8,
    parameter int WAIT_W = 4,
    parameter int LINE_BEATS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [SEL_W-1:0]  cfg_base,
    input  logic [SEL_W-1:0]  cfg_mask,
    input  logic              ts_n,
    input  logic              rw,
    input  logic [1:0]        siz,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              ack_oe,
    output logic              ack_n,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W/8-1:0] wr_be
);
    import bwa_pkg::*;

    localparam int BEAT_W = $clog2(LINE_BEATS);
    localparam int LANE_LO = $clog2(DATA_W / 8);

    state_e             state_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [1:0]         siz_q;
    logic [BEAT_W-1:0]  beat_q;
    logic               hit;
    logic               expired;
    logic               take;
    logic               ack_now;
    logic               last_beat;
    logic               reload;

    bwa_claim #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_claim (
        .ts_n     (ts_n),
        .rw       (rw),
        .addr     (addr),
        .cfg_base (cfg_base),
        .cfg_mask (cfg_mask),
        .hit      (hit)
    );

    bwa_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reload),
        .load_val (cfg_wait),
        .expired  (expired)
    );

    // Beat control decodes.
    always_comb begin
        take      = (state_q == ST_IDLE) && hit;
        ack_now   = (state_q == ST_BEAT) && expired;
        last_beat = (siz_q != SZ_LINE) || (beat_q == BEAT_W'(LINE_BEATS - 1));
        reload    = take || (ack_now && !last_beat);
    end

    // Three-state acknowledge: released when idle, low only on a finished beat.
    always_comb begin
        ack_oe = (state_q != ST_IDLE);
        ack_n  = !ack_now;
    end

    // Transfer sequencing and burst address advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            siz_q   <= SZ_LONG;
            beat_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (take) begin
                    state_q <= ST_BEAT;
                    addr_q  <= addr;
                    siz_q   <= siz;
                    beat_q  <= '0;
                end
                ST_BEAT: if (ack_now) begin
                    if (last_beat) begin
                        state_q <= ST_TAIL;
                    end else begin
                        beat_q <= beat_q + 1'b1;
                        addr_q[LANE_LO +: BEAT_W] <= addr_q[LANE_LO +: BEAT_W] + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Latch the acknowledged beat with its lanes and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            wr_be    <= '0;
        end else begin
            wr_valid <= ack_now;
            if (ack_now) begin
                wr_addr <= addr_q;
                wr_be   <= lane_sel(siz_q, addr_q[1:0]);
                wr_data <= data & lane_mask(lane_sel(siz_q, addr_q[1:0]));
            end
        end
    end
endmodule

// File: rtl/bwa_checker.sv
// Temporal checks on the acknowledge and latched-beat outputs.
// Assumes synchronous active-low reset on rst_n.
module bwa_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ack_oe,
    input logic       ack_n,
    input logic       wr_valid,
    input logic [3:0] wr_be
);
    AST_ACK_LOW_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> ack_oe); // R2

    AST_VALID_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_oe && !ack_n) |=> wr_valid); // R7

    AST_VALID_HAS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(ack_oe && !ack_n)); // R7

    AST_RELEASE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_oe) |-> $past(ack_n)); // R6

    AST_NO_VALID_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_oe && !$past(ack_oe)) |-> !wr_valid); // R1

    AST_LANES_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_be != 4'b0000)); // R5

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!ack_oe && !wr_valid)); // R9
endmodule

bind burst_wr_ack_ctrl bwa_checker u_bwa_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_oe   (ack_oe),
    .ack_n    (ack_n),
    .wr_valid (wr_valid),
    .wr_be    (wr_be)
);

// File: tb/burst_wr_ack_ctrl_tb.sv
module burst_wr_ack_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_wait = 4'd0;
    logic [7:0]  cfg_base = 8'hA5;
    logic [7:0]  cfg_mask = 8'hF0;
    logic        ts_n = 1'b1;
    logic        rw = 1'b0;
    logic [1:0]  siz = 2'b00;
    logic [27:0] addr = '0;
    logic [31:0] data = '0;
    logic        ack_oe, ack_n, wr_valid;
    logic [27:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;

    int checks = 0;
    int errors = 0;
    logic [31:0] drv [0:80];

    burst_wr_ack_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .cfg_base(cfg_base),
        .cfg_mask(cfg_mask), .ts_n(ts_n), .rw(rw), .siz(siz), .addr(addr),
        .data(data), .ack_oe(ack_oe), .ack_n(ack_n), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
    );

    always #5 clk = ~clk;

    function automatic logic [3:0] exp_be(input logic [1:0] s, input logic [1:0] lo);
        if (s == 2'b01) return 4'b1000 >> lo;
        if (s == 2'b10) return lo[1] ? 4'b0011 : 4'b1100;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] exp_mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [27:0] exp_addr(input logic [27:0] a, input int k);
        logic [27:0] r = a;
        r[3:2] = a[3:2] + 2'(k);
        return r;
    endfunction

    function automatic bit exp_claim(input logic [27:0] a, input logic r);
        return !r && (((a[27:20] ^ cfg_base) & cfg_mask) == 8'h00);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One transfer; retrig pulses a second strobe in cycle 2 (R8).
    task automatic xfer(input logic [27:0] a, input logic [1:0] s, input logic r,
                        input logic [3:0] w, input bit retrig);
        bit cl = exp_claim(a, r);
        int nb = (s == 2'b11) ? 4 : 1;
        int per = int'(w) + 1;
        int total = nb * per + 3;
        @(negedge clk);
        cfg_wait = w; addr = a; siz = s; rw = r; ts_n = 1'b0;
        data = $urandom;
        for (int c = 1; c <= total; c++) begin
            @(negedge clk);
            ts_n = 1'b1;
            if (retrig && c == 2) begin
                ts_n = 1'b0; addr = a ^ 28'h000000C; siz = 2'b01;
            end
            drv[c] = $urandom;
            data = drv[c];
            begin
                bit e_oe, e_ackn, e_val;
                int k, pos, pk;
                e_oe = 1'b0; e_ackn = 1'b1; e_val = 1'b0; pk = 0;
                if (cl) begin
                    k = (c - 1) / per; pos = (c - 1) % per;
                    if (k < nb) begin
                        e_oe = 1'b1; e_ackn = (pos == int'(w)) ? 1'b0 : 1'b1;
                    end else if (c == nb * per + 1) begin
                        e_oe = 1'b1;
                    end
                    if (c >= 2 && ((c - 2) / per) < nb && ((c - 2) % per) == int'(w)) begin
                        e_val = 1'b1; pk = (c - 2) / per;
                    end
                end
                check(ack_oe == e_oe, cl ? "R2/R6" : "R1", "ack_oe", 64'(ack_oe), 64'(e_oe));
                if (e_oe)
                    check(ack_n == e_ackn, (w == 0) ? "R3" : "R2", "ack_n", 64'(ack_n), 64'(e_ackn));
                check(wr_valid == e_val, retrig ? "R8" : "R7", "wr_valid", 64'(wr_valid), 64'(e_val));
                if (e_val) begin
                    logic [27:0] ea = (nb == 4) ? exp_addr(a, pk) : a;
                    logic [3:0]  eb = exp_be(s, a[1:0]);
                    check(wr_addr == ea, "R4", "wr_addr", 64'(wr_addr), 64'(ea));
                    check(wr_be == eb, "R5", "wr_be", 64'(wr_be), 64'(eb));
                    check(wr_data == (drv[c-1] & exp_mask(eb)), "R7", "wr_data",
                          64'(wr_data), 64'(drv[c-1] & exp_mask(eb)));
                end
            end
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(ack_oe == 1'b0, "R9", "reset ack_oe", 64'(ack_oe), 64'd0);
        check(wr_valid == 1'b0, "R9", "reset wr_valid", 64'(wr_valid), 64'd0);
        @(negedge clk); rst_n = 1'b1;
        // Directed corners
        xfer(28'hA000004, 2'b11, 1'b0, 4'd0, 1'b0);   // R3 back-to-back line
        xfer(28'hA00000C, 2'b11, 1'b0, 4'd2, 1'b0);   // R4 wrap from beat 3
        xfer(28'hA100002, 2'b10, 1'b0, 4'd1, 1'b0);   // R5 low word
        xfer(28'hA100003, 2'b01, 1'b0, 4'd0, 1'b0);   // R5 last byte
        xfer(28'hB000000, 2'b00, 1'b0, 4'd1, 1'b0);   // R1 window miss
        xfer(28'hA000000, 2'b00, 1'b1, 4'd1, 1'b0);   // R1 read not claimed
        xfer(28'hA000008, 2'b11, 1'b0, 4'd1, 1'b1);   // R8 strobe while busy
        xfer(28'hA000000, 2'b00, 1'b0, 4'd15, 1'b0);  // R2 long wait
        // Random mix
        for (int i = 0; i < 60; i++) begin
            logic [27:0] a = $urandom;
            if ($urandom_range(0, 3) != 0) a[27:24] = 4'hA;
            xfer(a, 2'($urandom), ($urandom_range(0, 7) == 0), 4'($urandom_range(0, 4)),
                 ($urandom_range(0, 5) == 0));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule